// File: doc/BRIEF.md
# Coincident-Decoded Word Memory

This block is a synchronous word memory of 1024 locations, each 16 bits wide. A word is not picked with a single flat index into the storage. The 10-bit address is cut into two 5-bit halves. Each half feeds its own 5-to-32 one-hot decoder. The upper half drives the row lines and the lower half drives the column lines. A storage word takes part in a write or a read only at the crossing where both its row line and its column line are active. The read path is an AND-OR gather over those crossings. Both decoder outputs are brought out as ports so that their one-hot behaviour can be observed.

To store a word, present the address and the data, then raise the write strobe. The word is committed on the next rising clock edge. To fetch a word, present the address and raise the read strobe. The word is captured into the read-data register on that edge and appears on the output during the following cycle. When both strobes are high, the write is performed and the read-data register keeps its old value. After reset the storage contents are unknown, and only the read-data register is cleared.

Top module: `coinc_word_mem`

## Requirements
- R1: Every one of the 1024 addresses holds an independent 16-bit word: a value written to an address is returned by a later read of that address.
- R2: The row select output is one-hot for every address, with bit number equal to address bits [9:5].
- R3: The column select output is one-hot for every address, with bit number equal to address bits [4:0].
- R4: A write with the write strobe high is committed on the rising edge and changes only the word at the addressed row/column crossing; words that share only its row or only its column are left unchanged.
- R5: Read data is registered. A read strobe sampled high on a rising edge (with the write strobe low) places the addressed word on the read-data output after that edge, and not before it.
- R6: While the read strobe is low, the read-data output holds its value even when the address changes.
- R7: When the read and write strobes are both high in the same cycle, the write is performed and the read-data output holds its previous value.
- R8: A synchronous active-low reset clears the read-data output to zero on the next rising edge.
- R9: With the write strobe low, data on the write bus has no effect on the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | 10 | Word address; bits [9:5] pick the row, bits [4:0] pick the column |
| wr_data_i | input | 16 | Data to store |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Registered read data |
| row_sel_o | output | 32 | One-hot row select lines |
| col_sel_o | output | 32 | One-hot column select lines |

## Verification
The bench sweeps all 1024 addresses through both decoders. A swapped or shifted address split would light the wrong line, and a broken decode would light none or two. It then fills every word with an arithmetic pattern and reads each one back. Any aliasing between crossings returns another address's pattern, and a read path without its register shows data a cycle early. Neighbours that share the row or the column of a rewritten word are read back to catch selection that ignores one of the two lines. Separate checks target a read that collides with a write, a read strobe that is low while the address moves, and a write strobe that is low while the data bus changes. In those cases a faulty design would update the output or the storage when it should not.

// File: rtl/cdm_pkg.sv
// Package: shared defaults for the coincident-decoded word memory.
// Assumes: the address width is even so both decoder halves match.
package cdm_pkg;
    localparam int unsigned ADDR_W_DEF = 10;
    localparam int unsigned DATA_W_DEF = 16;
endpackage

// File: rtl/coinc_line_decoder.sv
// Module: coinc_line_decoder
// Turns a SEL_W-bit field into 2**SEL_W select lines. Exactly one line is
// high for every known input value.
// Assumes: LINES equals 2**SEL_W.
module coinc_line_decoder #(
    parameter int unsigned SEL_W = 5,
    parameter int unsigned LINES = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [LINES-1:0] line_o
);
    // Compare the field against each line number.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            line_o[i] = (sel_i == SEL_W'(i));
        end
    end
endmodule

// File: rtl/coinc_cell_plane.sv
// Module: coinc_cell_plane
// Storage grid of ROWS x COLS words. A word is written or gathered only
// where its row line and column line are both high.
// Assumes: row_sel_i and col_sel_i are one-hot. Storage has no reset.
module coinc_cell_plane #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ROWS   = 32,
    parameter int unsigned COLS   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROWS-1:0]   row_sel_i,
    input  logic [COLS-1:0]   col_sel_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] cells [ROWS][COLS];
    logic [DATA_W-1:0] gathered;

    // Commit the write data into the word at the active crossing.
    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (wr_en_i && row_sel_i[r] && col_sel_i[c]) begin
                    cells[r][c] <= wr_data_i;
                end
            end
        end
    end

    // AND-OR gather of the word at the active crossing.
    always_comb begin
        gathered = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (row_sel_i[r] && col_sel_i[c]) begin
                    gathered = gathered | cells[r][c];
                end
            end
        end
    end

    // Read register: cleared by reset, loaded only by a read without a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i && !wr_en_i) begin
            rd_data_o <= gathered;
        end
    end
endmodule

// File: rtl/coinc_word_mem.sv
// Module: coinc_word_mem (top)
// Word memory whose address is split in two halves. The upper half drives
// a row decoder and the lower half drives a column decoder. Selection is
// the coincidence of the two one-hot line sets.
// Assumes: ADDR_W is even. Contents are unknown until written.
module coinc_word_mem #(
    parameter int unsigned ADDR_W = cdm_pkg::ADDR_W_DEF,
    parameter int unsigned DATA_W = cdm_pkg::DATA_W_DEF,
    localparam int unsigned COL_W = ADDR_W / 2,
    localparam int unsigned ROW_W = ADDR_W - COL_W,
    localparam int unsigned ROWS  = 1 << ROW_W,
    localparam int unsigned COLS  = 1 << COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [ROWS-1:0]   row_sel_o,
    output logic [COLS-1:0]   col_sel_o
);
    coinc_line_decoder #(.SEL_W(ROW_W), .LINES(ROWS)) row_dec_i (
        .sel_i  (addr_i[ADDR_W-1:COL_W]),
        .line_o (row_sel_o)
    );

    coinc_line_decoder #(.SEL_W(COL_W), .LINES(COLS)) col_dec_i (
        .sel_i  (addr_i[COL_W-1:0]),
        .line_o (col_sel_o)
    );

    coinc_cell_plane #(.DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS)) plane_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_sel_i (row_sel_o),
        .col_sel_i (col_sel_o),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o)
    );

    // R2
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_sel_o) == 1);

    // R2
    row_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_sel_o[addr_i[ADDR_W-1:COL_W]] == 1'b1);

    // R3
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_sel_o) == 1);

    // R3
    col_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_sel_o[addr_i[COL_W-1:0]] == 1'b1);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));

    // R7
    collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && wr_en_i) |=> $stable(rd_data_o));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> rd_data_o == '0);
endmodule

// File: tb/coinc_word_mem_tb_top.sv
module coinc_word_mem_tb_top;
    localparam int AW = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [DW-1:0] rdata;
    logic [31:0]   rsel;
    logic [31:0]   csel;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    coinc_word_mem dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_data_i(wdata),
        .wr_en_i(wr), .rd_en_i(rd), .rd_data_o(rdata),
        .row_sel_o(rsel), .col_sel_o(csel)
    );

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 613) ^ 16'h5A3C);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each task starts and ends just after a falling edge.
    task automatic do_write(input int a, input logic [DW-1:0] d);
        addr = AW'(a); wdata = d; wr = 1'b1; rd = 1'b0;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_read(input int a);
        addr = AW'(a); rd = 1'b1; wr = 1'b0;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] held;
        rd = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset clears read data
        check("R8", 32'(rdata), 32'h0);
        rst_n = 1'b1; rd = 1'b0;
        @(negedge clk);
        check("R8", 32'(rdata), 32'h0);

        // R2 R3: decoder sweep over every address
        for (int a = 0; a < 1024; a++) begin
            addr = AW'(a);
            #1;
            check("R2", rsel, 32'h1 << (a >> 5));
            check("R3", csel, 32'h1 << (a & 31));
        end
        @(negedge clk);

        // R1: fill every word
        for (int a = 0; a < 1024; a++) do_write(a, pat(a));

        // R5: data not visible before the capturing edge
        addr = AW'(7); rd = 1'b1;
        #1;
        check("R5", 32'(rdata), 32'h0);
        @(negedge clk);
        rd = 1'b0;
        check("R5", 32'(rdata), 32'(pat(7)));

        // R1 R5: read every word back one cycle after its strobe
        for (int a = 0; a < 1024; a++) begin
            do_read(a);
            check("R1", 32'(rdata), 32'(pat(a)));
        end

        // R6: idle read strobe, moving address
        held = rdata;
        for (int a = 0; a < 8; a++) begin
            addr = AW'(a * 97);
            @(negedge clk);
            check("R6", 32'(rdata), 32'(held));
        end

        // R9: write strobe low, data bus changes
        addr = AW'(5); wdata = 16'hDEAD; wr = 1'b0;
        @(negedge clk);
        do_read(5);
        check("R9", 32'(rdata), 32'(pat(5)));

        // R4: rewrite 0x21, neighbours on same row/column untouched
        do_write(12'h21, 16'hBEEF);
        do_read(12'h21);
        check("R4", 32'(rdata), 32'hBEEF);
        do_read(12'h20);
        check("R4", 32'(rdata), 32'(pat(12'h20)));
        do_read(12'h22);
        check("R4", 32'(rdata), 32'(pat(12'h22)));
        do_read(12'h01);
        check("R4", 32'(rdata), 32'(pat(12'h01)));
        do_read(12'h41);
        check("R4", 32'(rdata), 32'(pat(12'h41)));

        // R7: both strobes, write wins, output holds
        held = rdata;
        addr = AW'(12'h33); wdata = 16'h1234; wr = 1'b1; rd = 1'b1;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        check("R7", 32'(rdata), 32'(held));
        do_read(12'h33);
        check("R7", 32'(rdata), 32'h1234);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule